// File: doc/BRIEF.md
# Page-Aware Asynchronous PSRAM Read/Write Controller

This block sits between a synchronous host request port and an asynchronous pseudo-static RAM with a 16-bit word bus. It turns each accepted host request into a timed sequence on the memory strobes: chip enable, output enable, write enable and the two byte-lane enables. Every access time is counted in clock cycles and set by a parameter. The memory data bus is split into an output word, an output-enable qualifier and an input word, so a pad ring can build the tri-state driver.

Reads leave the chip enabled and the output enable active. The block therefore remembers the 16-word page that was read last. A following read that differs only in the four low address bits is served with the short page access time. Any other read pays the full random access time. Writes always run a complete, fixed-length cycle and then raise chip enable for a recovery period. A counter tracks how long chip enable has been low and closes the open page before the device's refresh-imposed limit is reached.

Top module: `psram_page_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it ends, chip enable, output enable, write enable and both lane enables are high (inactive), the bus driver qualifier and rsp_valid are low, and req_ready is high.
- R2: A read with a non-zero byte mask that is accepted with chip enable high raises rsp_valid for one cycle, T_RAND+1 cycles after the accepting edge, and rsp_rdata holds the word read from the addressed location.
- R3: A read accepted while the page is open whose address bits above bit 3 match the previous read returns after T_PAGE+1 cycles, and chip enable stays low from that previous read to this one.
- R4: A read accepted while the page is open whose address differs in bit 4 or higher takes T_RAND+1 cycles.
- R5: A write drives write enable low for exactly T_WP consecutive cycles while chip enable is low. Chip enable then stays high for at least T_CEH cycles before any later access.
- R6: A write accepted while the page is open gets no page speedup: it takes the same full write cycle, it closes the page, and the next read takes T_RAND+1 cycles.
- R7: Mask bit 1 selects the upper lane (bits 15:8) and mask bit 0 the lower lane (bits 7:0). On a read, a lane whose mask bit is 0 is returned as zero, whatever the memory bus carries on it.
- R8: On a write, only lanes whose mask bit is 1 have their lane enable asserted, so the stored value of a masked-off lane is unchanged.
- R9: A request with mask 2'b00 starts no memory access and changes no stored word. A read request with that mask returns rsp_valid with rsp_rdata zero one cycle after acceptance. Whenever chip enable is low, at least one lane enable is low.
- R10: Chip enable never stays low for more than T_CEM consecutive cycles. An open page is closed by raising chip enable, even while reads to it keep arriving or while the host is idle.
- R11: The bus driver qualifier is high only while chip enable is low and output enable is high. Output enable falls only after the qualifier has been low for at least one cycle.
- R12: During a write, the write word and address stay constant while write enable is low, and in the cycle in which write enable rises. In that cycle the bus is still driven and chip enable is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Lane mask: bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 16 | Read word, masked-off lanes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | 16 | Word driven onto the memory bus |
| mem_dq_oe | output | 1 | Bus driver enable for mem_dq_o |
| mem_dq_i | input | 16 | Word read from the memory bus |

## Verification
A page tag that is stale or wrong shows up first at rsp_valid: the read completes T_RAND-T_PAGE cycles early and returns a word from the wrong page, so a latency check on the first read after a page change exposes it. A low-time counter that is off or stuck lets chip enable run past T_CEM within one page sequence of back-to-back hits. A fault in the write sequence shows within the same write as a wrong write-enable pulse length, a bus that is released early, or a stored word whose lanes differ when it is read back.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int unsigned PS_DW = 16;
    localparam int unsigned PS_NB = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECOVER,
        ST_READ,
        ST_OPEN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD
    } pstate_e;

endpackage

// File: rtl/psram_ce_guard.sv
// Counts consecutive cycles with chip enable low and flags when one more
// worst-case access would break the low-time limit (R10).
module psram_ce_guard #(
    parameter int unsigned T_CEM = 1000,
    parameter int unsigned NEED  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic no_room
);
    localparam int unsigned GW = $clog2(T_CEM + 2);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ce_n) begin
            cnt_d = '0;
        end else if (cnt_q != {GW{1'b1}}) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign no_room = (32'(cnt_q) + NEED + 32'd1) > T_CEM;

endmodule

// File: rtl/psram_page_tag.sv
// Holds the page number of the last started read and compares it (R3, R4).
module psram_page_tag #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_page,
    input  logic [TW-1:0] cmp_page,
    output logic          hit
);
    logic [TW-1:0] tag_d, tag_q;

    always_comb begin
        tag_d = load ? load_page : tag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign hit = (tag_q == cmp_page);

endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned AW      = 20,
    parameter int unsigned PG_BITS = 4,
    parameter int unsigned T_RAND  = 6,
    parameter int unsigned T_PAGE  = 2,
    parameter int unsigned T_WP    = 4,
    parameter int unsigned T_CEH   = 2,
    parameter int unsigned T_CEM   = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [PS_DW-1:0]    req_wdata,
    input  logic [PS_NB-1:0]    req_be,
    output logic                rsp_valid,
    output logic [PS_DW-1:0]    rsp_rdata,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_ub_n,
    output logic                mem_lb_n,
    output logic [AW-1:0]       mem_addr,
    output logic [PS_DW-1:0]    mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [PS_DW-1:0]    mem_dq_i
);
    localparam int unsigned TA   = (T_RAND > T_PAGE) ? T_RAND : T_PAGE;
    localparam int unsigned TB   = (T_WP > T_CEH) ? T_WP : T_CEH;
    localparam int unsigned TMAX = (TA > TB) ? TA : TB;
    localparam int unsigned CW   = $clog2(TMAX + 1);
    localparam int unsigned TW   = AW - PG_BITS;
    // longest stretch of further low cycles one accepted request can add
    localparam int unsigned NEED = ((T_RAND + 1) > (T_WP + 2)) ? (T_RAND + 1) : (T_WP + 2);

    typedef struct packed {
        pstate_e          st;
        logic [CW-1:0]    cnt;
        logic [AW-1:0]    addr;
        logic [PS_DW-1:0] wdata;
        logic [PS_NB-1:0] be;
        logic             ce_n;
        logic             oe_n;
        logic             we_n;
        logic             dq_oe;
        logic             rvld;
        logic [PS_DW-1:0] rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, cnt: '0, addr: '0, wdata: '0, be: '0,
        ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0,
        rvld: 1'b0, rdata: '0
    };

    regs_t r_d, r_q;
    logic  no_room;
    logic  page_hit;
    logic  tag_load;
    logic  accept;

    psram_ce_guard #(
        .T_CEM (T_CEM),
        .NEED  (NEED)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (r_q.ce_n),
        .no_room (no_room)
    );

    psram_page_tag #(
        .TW (TW)
    ) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tag_load),
        .load_page (req_addr[AW-1:PG_BITS]),
        .cmp_page  (req_addr[AW-1:PG_BITS]),
        .hit       (page_hit)
    );

    // ready depends on state only, never on req_valid
    assign req_ready = (r_q.st == ST_IDLE) || ((r_q.st == ST_OPEN) && !no_room);
    assign accept    = req_valid && req_ready;

    always_comb begin
        r_d      = r_q;
        r_d.rvld = 1'b0;
        tag_load = 1'b0;

        if (accept) begin
            if (req_be == '0) begin
                // R9: empty mask, no access, read answers zero
                r_d.rvld  = !req_write;
                r_d.rdata = '0;
            end else begin
                r_d.addr  = req_addr;
                r_d.be    = req_be;
                r_d.wdata = req_wdata;
                r_d.ce_n  = 1'b0;
                if (req_write) begin
                    r_d.st   = ST_WSETUP;
                    r_d.oe_n = 1'b1;
                end else begin
                    r_d.st   = ST_READ;
                    r_d.oe_n = 1'b0;
                    tag_load = 1'b1;
                    r_d.cnt  = ((r_q.st == ST_OPEN) && page_hit) ?
                               CW'(T_PAGE - 1) : CW'(T_RAND - 1);
                end
            end
        end else begin
            unique case (r_q.st)
                ST_OPEN: begin
                    if (no_room) begin
                        r_d.st   = ST_RECOVER;
                        r_d.ce_n = 1'b1;
                        r_d.oe_n = 1'b1;
                        r_d.cnt  = CW'(T_CEH - 1);
                    end
                end
                ST_READ: begin
                    if (r_q.cnt == '0) begin
                        r_d.st    = ST_OPEN;
                        r_d.rvld  = 1'b1;
                        r_d.rdata = {r_q.be[1] ? mem_dq_i[15:8] : 8'h00,
                                     r_q.be[0] ? mem_dq_i[7:0]  : 8'h00};
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                ST_WSETUP: begin
                    r_d.st    = ST_WPULSE;
                    r_d.we_n  = 1'b0;
                    r_d.dq_oe = 1'b1;
                    r_d.cnt   = CW'(T_WP - 1);
                end
                ST_WPULSE: begin
                    if (r_q.cnt == '0) begin
                        r_d.st   = ST_WHOLD;
                        r_d.we_n = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                ST_WHOLD: begin
                    r_d.st    = ST_RECOVER;
                    r_d.ce_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.cnt   = CW'(T_CEH - 1);
                end
                ST_RECOVER: begin
                    if (r_q.cnt == '0) r_d.st  = ST_IDLE;
                    else               r_d.cnt = r_q.cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.rvld;
    assign rsp_rdata = r_q.rdata;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_ub_n  = r_q.ce_n | ~r_q.be[1];
    assign mem_lb_n  = r_q.ce_n | ~r_q.be[0];
    assign mem_addr  = r_q.addr;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.dq_oe;

endmodule

// File: rtl/psram_page_ctrl_chk.sv
module psram_page_ctrl_chk #(
    parameter int unsigned AW    = 20,
    parameter int unsigned T_CEM = 1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_ub_n,
    input logic          mem_lb_n,
    input logic [AW-1:0] mem_addr,
    input logic [15:0]   mem_dq_o,
    input logic          mem_dq_oe
);
    localparam int unsigned GW = $clog2(T_CEM + 2);

    logic [GW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     run_q <= '0;
        else if (mem_ce_n)              run_q <= '0;
        else if (run_q != {GW{1'b1}})   run_q <= run_q + 1'b1;
    end

    p_ce_low_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (32'(run_q) < T_CEM));

    p_no_empty_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !(mem_ub_n && mem_lb_n));

    p_drive_only_writing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    p_oe_after_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    p_we_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    p_pulse_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_o) && $stable(mem_addr)));

    p_hold_after_we_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_o) && $stable(mem_addr)));

endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(
    .AW    (AW),
    .T_CEM (T_CEM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_psram_page_ctrl.sv
module tb_psram_page_ctrl;
    localparam int AW     = 8;
    localparam int T_RAND = 6;
    localparam int T_PAGE = 2;
    localparam int T_WP   = 4;
    localparam int T_CEH  = 2;
    localparam int T_CEM  = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_be = '0;
    logic          rsp_valid;
    logic [15:0]   rsp_rdata;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_dq_o;
    logic          mem_dq_oe;
    logic [15:0]   mem_dq_i;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] mdl [256];
    logic [15:0] shd [256];

    // monitor state
    int we_run = 0, last_we_len = 0, we_rises = 0;
    int ce_low_run = 0, max_ce_low = 0, ce_rises = 0, ce_falls = 0;
    int ce_high_run = 0, min_ce_high = 1000;
    int bus_viol = 0, hold_viol = 0;
    logic prev_we = 1'b1, prev_ce = 1'b1, prev_dqoe = 1'b0, seen_low = 1'b0;
    logic [15:0] data_at_fall = '0;

    always #2 clk = ~clk;

    psram_page_ctrl #(
        .AW(AW), .PG_BITS(4), .T_RAND(T_RAND), .T_PAGE(T_PAGE),
        .T_WP(T_WP), .T_CEH(T_CEH), .T_CEM(T_CEM)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // memory model: disabled lanes carry junk that must be ignored
    assign mem_dq_i = {(!mem_ub_n ? mdl[mem_addr][15:8] : 8'hA5),
                       (!mem_lb_n ? mdl[mem_addr][7:0]  : 8'h5A)};

    function automatic logic [15:0] init_word(int a);
        return {8'(a) ^ 8'h5A, 8'(a) + 8'h31};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) bus_viol++;
            if (!mem_oe_n && prev_ce == mem_ce_n && prev_dqoe && !mem_dq_oe) bus_viol++;
            if (!mem_we_n) begin
                if (prev_we) data_at_fall = mem_dq_o;
                we_run++;
            end else if (!prev_we) begin
                last_we_len = we_run;
                we_run = 0;
                we_rises++;
                if (!mem_dq_oe || mem_ce_n || mem_dq_o != data_at_fall) hold_viol++;
                if (!mem_ub_n) mdl[mem_addr][15:8] = mem_dq_o[15:8];
                if (!mem_lb_n) mdl[mem_addr][7:0]  = mem_dq_o[7:0];
            end
            if (!mem_ce_n) begin
                if (prev_ce) begin
                    ce_falls++;
                    if (seen_low && ce_high_run < min_ce_high) min_ce_high = ce_high_run;
                    ce_low_run = 0;
                end
                ce_low_run++;
                if (ce_low_run > max_ce_low) max_ce_low = ce_low_run;
                seen_low = 1'b1;
            end else begin
                if (!prev_ce) begin
                    ce_rises++;
                    ce_high_run = 0;
                end
                ce_high_run++;
            end
            prev_we   = mem_we_n;
            prev_ce   = mem_ce_n;
            prev_dqoe = mem_dq_oe;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] be,
                           output int lat, output logic [15:0] data);
        issue(1'b0, a, 16'h0, be);
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        data = rsp_rdata;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                            input logic [1:0] be);
        issue(1'b1, a, d, be);
        if (be[1]) shd[a][15:8] = d[15:8];
        if (be[0]) shd[a][7:0]  = d[7:0];
        while (!req_ready) @(negedge clk);
    endtask

    function automatic logic [15:0] masked(logic [15:0] w, logic [1:0] be);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic t_reset;
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n, "R1",
              "strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'h1f);
        check(!mem_dq_oe && !rsp_valid, "R1", "driver/rsp in reset",
              {mem_dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1", "ready after reset", req_ready, 1);
        check(mem_ce_n && !mem_dq_oe, "R1", "idle after reset", {mem_ce_n, mem_dq_oe}, 2'b10);
    endtask

    task automatic t_random_read;
        int lat; logic [15:0] d;
        do_read(8'h23, 2'b11, lat, d);
        check(lat == T_RAND + 1, "R2", "random read latency", lat, T_RAND + 1);
        check(d == shd[8'h23], "R2", "random read data", d, shd[8'h23]);
    endtask

    task automatic t_page_hit;
        int lat; int rises; logic [15:0] d;
        rises = ce_rises;
        do_read(8'h2A, 2'b11, lat, d);
        check(lat == T_PAGE + 1, "R3", "page hit latency", lat, T_PAGE + 1);
        check(d == shd[8'h2A], "R3", "page hit data", d, shd[8'h2A]);
        do_read(8'h20, 2'b11, lat, d);
        check(lat == T_PAGE + 1, "R3", "second hit latency", lat, T_PAGE + 1);
        check(d == shd[8'h20], "R3", "second hit data", d, shd[8'h20]);
        check(ce_rises == rises, "R3", "ce stayed low in page", ce_rises, rises);
    endtask

    task automatic t_page_miss;
        int lat; logic [15:0] d;
        do_read(8'h45, 2'b11, lat, d);
        check(lat == T_RAND + 1, "R4", "page miss latency", lat, T_RAND + 1);
        check(d == shd[8'h45], "R4", "page miss data", d, shd[8'h45]);
    endtask

    task automatic t_read_lanes;
        int lat; logic [15:0] d;
        do_read(8'h46, 2'b01, lat, d);
        check(d == masked(shd[8'h46], 2'b01), "R7", "lower-only read", d, masked(shd[8'h46], 2'b01));
        do_read(8'h47, 2'b10, lat, d);
        check(d == masked(shd[8'h47], 2'b10), "R7", "upper-only read", d, masked(shd[8'h47], 2'b10));
    endtask

    task automatic t_writes;
        int lat; int rises; logic [15:0] d;
        rises = we_rises;
        do_write(8'h47, 16'h1234, 2'b11);
        check(we_rises == rises + 1, "R6", "write after read issued", we_rises, rises + 1);
        check(last_we_len == T_WP, "R5", "write pulse length", last_we_len, T_WP);
        do_read(8'h47, 2'b11, lat, d);
        check(lat == T_RAND + 1, "R6", "read after write not page", lat, T_RAND + 1);
        check(d == 16'h1234, "R5", "full word written", d, 16'h1234);
        do_write(8'h48, 16'hBEEF, 2'b01);
        check(last_we_len == T_WP, "R5", "pulse length from idle", last_we_len, T_WP);
        do_read(8'h48, 2'b11, lat, d);
        check(d == shd[8'h48], "R8", "lower lane write only", d, shd[8'h48]);
        do_write(8'h49, 16'hC0DE, 2'b10);
        do_read(8'h49, 2'b11, lat, d);
        check(d == shd[8'h49], "R8", "upper lane write only", d, shd[8'h49]);
        check(min_ce_high >= T_CEH, "R5", "ce recovery length", min_ce_high, T_CEH);
    endtask

    task automatic t_null;
        int lat; int falls; int rises; logic [15:0] d;
        repeat (60) @(negedge clk);   // page closed by R10, controller idle
        falls = ce_falls;
        rises = we_rises;
        do_read(8'h10, 2'b00, lat, d);
        check(lat == 1, "R9", "empty-mask read latency", lat, 1);
        check(d == 16'h0000, "R9", "empty-mask read data", d, 0);
        do_write(8'h10, 16'hFFFF, 2'b00);
        @(negedge clk);
        check(ce_falls == falls, "R9", "no access on empty mask", ce_falls, falls);
        check(we_rises == rises, "R9", "no write strobe on empty mask", we_rises, rises);
        do_read(8'h10, 2'b11, lat, d);
        check(d == shd[8'h10], "R9", "word untouched", d, shd[8'h10]);
    endtask

    task automatic t_ce_limit;
        int lat; int rises; logic [15:0] d;
        rises = ce_rises;
        for (int i = 0; i < 24; i++) begin
            do_read(8'h60 + 8'(i % 16), 2'b11, lat, d);
            if (d != shd[8'h60 + (i % 16)])
                check(1'b0, "R10", "data during long page", d, shd[8'h60 + (i % 16)]);
        end
        check(max_ce_low <= T_CEM, "R10", "longest ce low", max_ce_low, T_CEM);
        check(ce_rises > rises, "R10", "page forced closed", ce_rises, rises + 1);
        do_read(8'h61, 2'b11, lat, d);
        repeat (T_CEM + 5) @(negedge clk);
        check(mem_ce_n == 1'b1, "R10", "idle page closed", mem_ce_n, 1);
    endtask

    task automatic t_bus;
        check(bus_viol == 0, "R11", "bus driver/output enable overlap", bus_viol, 0);
        check(hold_viol == 0, "R12", "write data hold", hold_viol, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mdl[i] = init_word(i);
            shd[i] = init_word(i);
        end
        repeat (3) @(negedge clk);
        t_reset();
        t_random_read();
        t_page_hit();
        t_page_miss();
        t_read_lanes();
        t_writes();
        t_null();
        t_ce_limit();
        t_bus();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1-watchdog run did not finish: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule